// File: doc/BRIEF.md
# Pixel Output Formatter and Strobe Generator

This block sits between a 10-bit pixel converter and a parallel output bus. Each accepted sample is recoded into one of four output formats, placed on a 10-bit data bus, and framed by a data-ready strobe. The strobe frame has three phases, each set separately: a setup phase in which data is already on the bus, a pulse phase in which the strobe is active, and a hold phase in which the data stays on the bus. The strobe polarity can be inverted. A busy output tells the sample source when the next sample may be offered.

The control sequencer has four named states. IDLE waits for a sample. SETUP counts the setup clocks. PULSE drives the strobe active. HOLD keeps the data after the strobe. The transitions are as follows. IDLE goes to SETUP when a sample is offered and the setup count is non-zero, and to PULSE when the setup count is zero. SETUP goes to PULSE when its count runs out. PULSE goes to HOLD when its count runs out and the hold count is non-zero, and to IDLE when the hold count is zero. HOLD goes to IDLE when its count runs out. While in IDLE, a sample with its valid bit high is accepted at the clock edge. Format, data, pulse width and hold count are all captured at that edge.

Top module: `pof_out_fmt`

## Requirements
- R1: After reset, busy is 0, the data bus is 0 and the strobe sits at its inactive level.
- R2: Format select 00 puts all ten sample bits on the data bus unchanged.
- R3: Format select 01 forces bus bits 1:0 to 0. Bus bits 9:2 carry sample bits 9:2 plus sample bit 1, saturating at 0xFF rather than wrapping.
- R4: Format select 10 forces bus bits 1:0 to 0. Bus bits 9:2 are 0xFF when sample bit 9 or bit 8 is 1, and sample bits 7:0 otherwise.
- R5: Format select 11 forces bus bits 1:0 to 0. Bus bits 9:2 are 0xFF when sample bit 9 is 1, and sample bits 8:1 otherwise.
- R6: Counting from the first clock after acceptance, the coded data is on the bus for S clocks (S = setup count, 0..3) with the strobe inactive before the strobe asserts.
- R7: The strobe is active for exactly W+1 consecutive clocks, where W is the 3-bit width code.
- R8: After the strobe drops, the data stays on the bus and busy stays 1 for H more clocks, where H is the 2-bit hold count.
- R9: With the polarity input at 0 the strobe is active high and idles low. With the polarity input at 1 it is active low and idles high.
- R10: Busy is 1 from the clock after acceptance until the hold phase ends, for S+W+2+H-1 clocks in total. While busy is 1, offered samples and changes to format, width, setup or hold are ignored, and the bus keeps the accepted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_data | input | 10 | Pixel sample |
| smp_valid | input | 1 | Sample offered this cycle |
| smp_fmt | input | 2 | Output format select |
| setup_cnt | input | 2 | Setup clocks before strobe |
| width_code | input | 3 | Strobe width minus one |
| hold_cnt | input | 2 | Hold clocks after strobe |
| strobe_inv | input | 1 | 1 selects active-low strobe |
| busy | output | 1 | Sample source must wait |
| out_data | output | 10 | Output data bus |
| out_strobe | output | 1 | Data-ready strobe |

## Verification
The hardest situation to reach is a sample source that keeps offering new samples, and changes the format and phase settings, in the middle of a frame. A source that respects busy never does this. The bench therefore runs frames in which valid is held high and every other input is scrambled on the cycle after acceptance. It then checks that the bus word, the phase lengths and the release of busy all still follow the values captured at acceptance. The bench also sweeps all 1024 sample values under every format, and every combination of setup, width, hold and polarity.

// File: rtl/pof_pkg.sv
package pof_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_PULSE  = 2'd2,
        PH_HOLD   = 2'd3
    } phase_t;

    typedef enum logic [1:0] {
        FMT_RAW       = 2'b00,
        FMT_ROUND     = 2'b01,
        FMT_CLIP_LOW  = 2'b10,
        FMT_CLIP_HIGH = 2'b11
    } fmt_t;
endpackage

// File: rtl/pof_coder.sv
module pof_coder #(
    parameter int ADC_W = 10
) (
    input  logic [ADC_W-1:0] adc,
    input  pof_pkg::fmt_t    fmt,
    output logic [ADC_W-1:0] word
);
    localparam int NW = ADC_W - 2;

    logic [NW:0]   rnd_sum;
    logic [NW-1:0] rnd_sat;
    logic [NW-1:0] clip_lo;
    logic [NW-1:0] clip_hi;

    always_comb begin
        rnd_sum = {1'b0, adc[ADC_W-1:2]} + {{NW{1'b0}}, adc[1]};
        rnd_sat = rnd_sum[NW] ? {NW{1'b1}} : rnd_sum[NW-1:0];
        clip_lo = (adc[ADC_W-1] | adc[ADC_W-2]) ? {NW{1'b1}} : adc[NW-1:0];
        clip_hi = adc[ADC_W-1] ? {NW{1'b1}} : adc[ADC_W-2:1];
    end

    always_comb begin
        unique case (fmt)
            pof_pkg::FMT_RAW:       word = adc;
            pof_pkg::FMT_ROUND:     word = {rnd_sat, 2'b00};
            pof_pkg::FMT_CLIP_LOW:  word = {clip_lo, 2'b00};
            pof_pkg::FMT_CLIP_HIGH: word = {clip_hi, 2'b00};
            default:                word = adc;
        endcase
    end
endmodule

// File: rtl/pof_phase_fsm.sv
module pof_phase_fsm #(
    parameter int SETUP_W = 2,
    parameter int WID_W   = 3,
    parameter int HOLD_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               smp_valid,
    input  logic [SETUP_W-1:0] setup_cnt,
    input  logic [WID_W-1:0]   width_code,
    input  logic [HOLD_W-1:0]  hold_cnt,
    output logic               accept,
    output logic               busy,
    output logic               strobe_act
);
    import pof_pkg::*;

    localparam int CNT_A = (SETUP_W > WID_W) ? SETUP_W : WID_W;
    localparam int CNT_W = (CNT_A > HOLD_W) ? CNT_A : HOLD_W;

    phase_t             phase_q, phase_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [WID_W-1:0]   width_q, width_d;
    logic [HOLD_W-1:0]  hold_q, hold_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            width_q <= '0;
            hold_q  <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
            width_q <= width_d;
            hold_q  <= hold_d;
        end
    end

    // next-state logic
    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        width_d = width_q;
        hold_d  = hold_q;
        unique case (phase_q)
            PH_IDLE: begin
                if (smp_valid) begin
                    width_d = width_code;
                    hold_d  = hold_cnt;
                    if (setup_cnt != '0) begin
                        phase_d = PH_SETUP;
                        cnt_d   = CNT_W'(setup_cnt) - CNT_W'(1);
                    end else begin
                        phase_d = PH_PULSE;
                        cnt_d   = CNT_W'(width_code);
                    end
                end
            end
            PH_SETUP: begin
                if (cnt_q == '0) begin
                    phase_d = PH_PULSE;
                    cnt_d   = CNT_W'(width_q);
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            PH_PULSE: begin
                if (cnt_q == '0) begin
                    if (hold_q != '0) begin
                        phase_d = PH_HOLD;
                        cnt_d   = CNT_W'(hold_q) - CNT_W'(1);
                    end else begin
                        phase_d = PH_IDLE;
                    end
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            PH_HOLD: begin
                if (cnt_q == '0) begin
                    phase_d = PH_IDLE;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept     = (phase_q == PH_IDLE) && smp_valid;
        busy       = (phase_q != PH_IDLE);
        strobe_act = (phase_q == PH_PULSE);
    end
endmodule

// File: rtl/pof_out_fmt.sv
module pof_out_fmt #(
    parameter int ADC_W   = 10,
    parameter int SETUP_W = 2,
    parameter int WID_W   = 3,
    parameter int HOLD_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADC_W-1:0]   smp_data,
    input  logic               smp_valid,
    input  logic [1:0]         smp_fmt,
    input  logic [SETUP_W-1:0] setup_cnt,
    input  logic [WID_W-1:0]   width_code,
    input  logic [HOLD_W-1:0]  hold_cnt,
    input  logic               strobe_inv,
    output logic               busy,
    output logic [ADC_W-1:0]   out_data,
    output logic               out_strobe
);
    logic             accept;
    logic             strobe_act;
    logic [ADC_W-1:0] coded;
    logic [ADC_W-1:0] data_q;

    pof_coder #(.ADC_W(ADC_W)) i_coder (
        .adc  (smp_data),
        .fmt  (pof_pkg::fmt_t'(smp_fmt)),
        .word (coded)
    );

    pof_phase_fsm #(
        .SETUP_W (SETUP_W),
        .WID_W   (WID_W),
        .HOLD_W  (HOLD_W)
    ) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_valid  (smp_valid),
        .setup_cnt  (setup_cnt),
        .width_code (width_code),
        .hold_cnt   (hold_cnt),
        .accept     (accept),
        .busy       (busy),
        .strobe_act (strobe_act)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)      data_q <= '0;
        else if (accept) data_q <= coded;
    end

    assign out_data   = data_q;
    assign out_strobe = strobe_act ^ strobe_inv;
endmodule

// File: rtl/pof_checker.sv
module pof_checker #(
    parameter int ADC_W   = 10,
    parameter int SETUP_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADC_W-1:0]   smp_data,
    input logic               smp_valid,
    input logic [1:0]         smp_fmt,
    input logic [SETUP_W-1:0] setup_cnt,
    input logic               strobe_inv,
    input logic               busy,
    input logic [ADC_W-1:0]   out_data,
    input logic               out_strobe
);
    logic       active;
    logic [3:0] run_len;

    assign active = out_strobe ^ strobe_inv;

    always_ff @(posedge clk) begin
        if (!rst_n)                       run_len <= '0;
        else if (active && run_len != '1) run_len <= run_len + 4'd1;
        else if (!active)                 run_len <= '0;
    end

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (!busy && out_data == '0 && !active));

    p_raw_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && smp_valid && smp_fmt == 2'b00) |=> out_data == $past(smp_data));

    p_low_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && smp_valid && smp_fmt != 2'b00) |=> out_data[1:0] == 2'b00);

    p_setup_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && smp_valid && setup_cnt != '0) |=> !active);

    p_pulse_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> run_len < 4'd8);

    p_idle_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> out_strobe == strobe_inv);

    p_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && smp_valid) |=> busy);

    p_data_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(out_data));
endmodule

bind pof_out_fmt pof_checker #(.ADC_W(ADC_W), .SETUP_W(SETUP_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_data   (smp_data),
    .smp_valid  (smp_valid),
    .smp_fmt    (smp_fmt),
    .setup_cnt  (setup_cnt),
    .strobe_inv (strobe_inv),
    .busy       (busy),
    .out_data   (out_data),
    .out_strobe (out_strobe)
);

// File: tb/test_pof_out_fmt.sv
module test_pof_out_fmt;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] smp_data = '0;
    logic       smp_valid = 1'b0;
    logic [1:0] smp_fmt = '0;
    logic [1:0] setup_cnt = '0;
    logic [2:0] width_code = '0;
    logic [1:0] hold_cnt = '0;
    logic       strobe_inv = 1'b0;
    logic       busy;
    logic [9:0] out_data;
    logic       out_strobe;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pof_out_fmt i_pof_out_fmt (
        .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .smp_valid(smp_valid),
        .smp_fmt(smp_fmt), .setup_cnt(setup_cnt), .width_code(width_code),
        .hold_cnt(hold_cnt), .strobe_inv(strobe_inv), .busy(busy),
        .out_data(out_data), .out_strobe(out_strobe)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int fmt_exp(input int a, input int f);
        int r;
        case (f)
            0: return a;
            1: begin
                r = (a + 2) / 4;
                if (r > 255) r = 255;
                return r * 4;
            end
            2: return (a >= 256) ? 1020 : (a % 256) * 4;
            default: return (a >= 512) ? 1020 : ((a / 2) % 256) * 4;
        endcase
    endfunction

    function automatic string fmt_tag(input int f);
        case (f)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            default: return "R5";
        endcase
    endfunction

    // One frame; noisy keeps valid high and scrambles inputs while busy (R10)
    task automatic run_one(input int a, input int f, input int s, input int w,
                           input int h, input int inv, input bit noisy);
        int exp_d;
        int total;
        int act_exp;
        string ptag;
        exp_d = fmt_exp(a, f);
        total = s + w + 1 + h;
        smp_data   = 10'(a);
        smp_fmt    = 2'(f);
        setup_cnt  = 2'(s);
        width_code = 3'(w);
        hold_cnt   = 2'(h);
        strobe_inv = inv[0];
        smp_valid  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        if (noisy) begin
            smp_data   = ~10'(a);
            smp_fmt    = 2'(f + 1);
            setup_cnt  = 2'(s + 1);
            width_code = 3'(w + 3);
            hold_cnt   = 2'(h + 2);
        end else begin
            smp_valid = 1'b0;
        end
        for (int i = 0; i < total; i++) begin
            if (i < s) ptag = "R6";
            else if (i < s + w + 1) ptag = "R7";
            else ptag = "R8";
            act_exp = ((i >= s && i < s + w + 1) ? 1 : 0) ^ inv;
            chk(out_strobe == act_exp[0], ptag, int'(out_strobe), act_exp);
            chk(busy == 1'b1, noisy ? "R10" : ptag, int'(busy), 1);
            chk(out_data == 10'(exp_d), noisy ? "R10" : fmt_tag(f), int'(out_data), exp_d);
            @(negedge clk);
        end
        smp_valid = 1'b0;
        chk(busy == 1'b0, "R10", int'(busy), 0);
        chk(out_strobe == inv[0], "R9", int'(out_strobe), inv);
        chk(out_data == 10'(exp_d), noisy ? "R10" : "R8", int'(out_data), exp_d);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1", int'(busy), 0);
        chk(out_data == 10'd0, "R1", int'(out_data), 0);
        chk(out_strobe == 1'b0, "R1", int'(out_strobe), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2..R5 exhaustive sample sweep under each format
        for (int f = 0; f < 4; f++)
            for (int a = 0; a < 1024; a++)
                run_one(a, f, 0, 0, 0, 0, 1'b0);
        // R6..R9 every phase combination, both polarities
        for (int inv = 0; inv < 2; inv++)
            for (int s = 0; s < 4; s++)
                for (int w = 0; w < 8; w++)
                    for (int h = 0; h < 4; h++)
                        run_one((s * 131 + w * 37 + h * 11 + inv * 500) % 1024,
                                (s + w + h) % 4, s, w, h, inv, 1'b0);
        // R10 inputs ignored while busy
        for (int k = 0; k < 32; k++)
            run_one((k * 97 + 5) % 1024, k % 4, k % 4, (k / 4) % 8, (k / 2) % 4, k % 2, 1'b1);
        // R9 idle level follows polarity input
        strobe_inv = 1'b1;
        @(negedge clk);
        chk(out_strobe == 1'b1, "R9", int'(out_strobe), 1);
        strobe_inv = 1'b0;
        @(negedge clk);
        chk(out_strobe == 1'b0, "R9", int'(out_strobe), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule